// File: doc/BRIEF.md
# Dual-Convention Byte Stack Engine

This block moves 8-bit and 16-bit values onto and off a stack that lives in byte-wide memory, and keeps the 16-bit stack pointer itself. A single request with an operation, a width and a convention selector starts one transfer. The block then drives the memory port for one or two byte cycles and pulses a completion strobe. A 16-bit value is stored with its most significant byte at the lower address, and it is always moved most significant byte first.

Two conventions are supported. In the *next-free* convention the pointer addresses the byte that the next push will fill. A push writes downward from the pointer, and a pop reads from the byte above the pointer. In the *last-used* convention the pointer addresses the most recently written byte. A push first moves the pointer down and then writes from the new pointer, and a pop reads from the pointer and then moves it up.

The sequencer has four states. **IDLE** waits for a request. A request taken in IDLE goes to **HIGH** for a 16-bit transfer or to **LOW** for an 8-bit one. HIGH always goes to LOW. LOW always goes to **FINISH**, which raises `done` for one clock and then returns to IDLE. The stack pointer takes its new value on the edge that enters FINISH.

Top module: `stack_ptr_engine`

## Requirements
- R1: After reset the stack pointer equals the parameter RESET_SP, and `done` and `mem_we` are low.
- R2: In next-free mode (`stack_mode`=0), an 8-bit push writes the byte at SP, and SP becomes SP-1.
- R3: In next-free mode, a 16-bit push writes the high byte at SP-1 and the low byte at SP, and SP becomes SP-2.
- R4: In next-free mode, a pop reads starting at SP+1, and SP grows by 1 for 8 bits or by 2 for 16 bits.
- R5: In last-used mode (`stack_mode`=1), a push lowers SP by 1 or 2 and then writes starting at the new SP.
- R6: In last-used mode, a pop reads starting at SP, and SP then grows by 1 or 2.
- R7: A 16-bit value is big-endian. The high byte is moved in the first byte cycle at address A, and the low byte is moved in the next cycle at A+1.
- R8: A request taken in IDLE puts the first byte on the port in the next cycle. After the last byte cycle, `done` is high for exactly one clock. That is 2 cycles from request to `done` for 8 bits and 3 cycles for 16 bits. `mem_we` is high only in byte cycles of a push.
- R9: The stack pointer and all stack addresses wrap modulo 2^16, and SP changes only on the edge that raises `done`.
- R10: A request that arrives while a transfer is in progress is ignored. It does not change the addresses, the data written or the final SP.
- R11: `pop_data` presents the popped value, with an 8-bit pop zero-extended into bits 15:8. It holds its value until the next pop captures a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start request, sampled in IDLE |
| op_pop | input | 1 | 1 = pop, 0 = push |
| op_wide | input | 1 | 1 = 16-bit value, 0 = 8-bit value |
| stack_mode | input | 1 | 0 = next-free convention, 1 = last-used convention |
| push_data | input | 16 | Value to push (bits 7:0 for 8-bit) |
| mem_rdata | input | 8 | Read byte from memory, valid in the same cycle as mem_addr |
| mem_addr | output | 16 | Byte address of the current byte cycle |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe |
| pop_data | output | 16 | Last popped value |
| done | output | 1 | One-clock completion strobe |
| sp | output | 16 | Current stack pointer |

## Verification
A cycle-accurate model in the bench runs all eight combinations of direction, width and convention. It compares the port against the model on every clock. The pointer starts two bytes above address zero, so a short mixed sequence crosses the 0x0000/0xFFFF boundary in both conventions. Popping back what was pushed shows whether the two conventions differ by the one-byte offset of their start address, and whether big-endian order is kept. A second request injected during a 16-bit push separates a sequencer that ignores mid-transfer requests from one that restarts or writes stray bytes.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2,
        ST_FIN  = 2'd3
    } stk_state_e;
endpackage

// File: rtl/stk_addr_gen.sv
// Start address and post-operation pointer for one request.
module stk_addr_gen #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] sp_cur,
    input  logic          op_pop,
    input  logic          op_wide,
    input  logic          last_used,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] sp_next
);
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    logic [AW-1:0] span;      // bytes moved
    logic [AW-1:0] span_m1;   // bytes moved minus one

    assign span    = op_wide ? TWO : ONE;
    assign span_m1 = op_wide ? ONE : '0;

    always_comb begin
        if (op_pop) begin
            sp_next    = sp_cur + span;
            start_addr = last_used ? sp_cur : sp_cur + ONE;
        end else begin
            sp_next    = sp_cur - span;
            start_addr = last_used ? sp_cur - span : sp_cur - span_m1;
        end
    end
endmodule

// File: rtl/stk_fsm.sv
// Byte sequencer: IDLE -> (HIGH ->) LOW -> FINISH -> IDLE.
module stk_fsm
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       op_wide,
    output stk_state_e state,
    output logic       accept,
    output logic       done
);
    stk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req) state_d = op_wide ? ST_HIGH : ST_LOW;
            ST_HIGH: state_d = ST_LOW;
            ST_LOW:  state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state  = state_q;
        accept = (state_q == ST_IDLE) && req;
        done   = (state_q == ST_FIN);
    end

    // R8: completion strobe lasts one clock
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a started transfer runs to completion whatever req does
    a_r10_high_to_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH) |=> (state_q == ST_LOW));

    // R8: the last byte cycle is always followed by completion
    a_r8_low_to_fin: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW) |=> done);
endmodule

// File: rtl/stk_ptr.sv
// Stack pointer register.
module stk_ptr #(
    parameter int              AW       = 16,
    parameter logic [AW-1:0]   RESET_SP = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] value,
    output logic [AW-1:0] sp_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sp_q <= RESET_SP;
        else if (load) sp_q <= value;
    end
endmodule

// File: rtl/stack_ptr_engine.sv
module stack_ptr_engine
    import stk_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            BW       = 8,
    parameter logic [AW-1:0] RESET_SP = AW'(16'h0100)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            op_pop,
    input  logic            op_wide,
    input  logic            stack_mode,
    input  logic [2*BW-1:0] push_data,
    input  logic [BW-1:0]   mem_rdata,
    output logic [AW-1:0]   mem_addr,
    output logic [BW-1:0]   mem_wdata,
    output logic            mem_we,
    output logic [2*BW-1:0] pop_data,
    output logic            done,
    output logic [AW-1:0]   sp
);
    localparam int WW = 2 * BW;

    stk_state_e    state;
    logic          accept;
    logic [AW-1:0] start_addr, sp_next;
    logic [AW-1:0] addr_q, nsp_q;
    logic [WW-1:0] wdata_q, pop_q;
    logic          is_pop_q, is_wide_q;
    logic          commit;

    stk_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .op_wide (op_wide),
        .state   (state),
        .accept  (accept),
        .done    (done)
    );

    stk_addr_gen #(.AW(AW)) u_addr (
        .sp_cur     (sp),
        .op_pop     (op_pop),
        .op_wide    (op_wide),
        .last_used  (stack_mode),
        .start_addr (start_addr),
        .sp_next    (sp_next)
    );

    assign commit = (state == ST_LOW);

    stk_ptr #(.AW(AW), .RESET_SP(RESET_SP)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (commit),
        .value (nsp_q),
        .sp_q  (sp)
    );

    // request capture and byte address stepping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            nsp_q     <= '0;
            wdata_q   <= '0;
            is_pop_q  <= 1'b0;
            is_wide_q <= 1'b0;
        end else if (accept) begin
            addr_q    <= start_addr;
            nsp_q     <= sp_next;
            wdata_q   <= push_data;
            is_pop_q  <= op_pop;
            is_wide_q <= op_wide;
        end else if (state == ST_HIGH) begin
            addr_q    <= addr_q + AW'(1);
        end
    end

    // pop value assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pop_q <= '0;
        end else if (is_pop_q) begin
            if (state == ST_HIGH)
                pop_q[WW-1:BW] <= mem_rdata;
            else if (state == ST_LOW)
                pop_q <= is_wide_q ? {pop_q[WW-1:BW], mem_rdata}
                                   : {{BW{1'b0}}, mem_rdata};
        end
    end

    // port outputs
    always_comb begin
        mem_addr  = addr_q;
        mem_we    = ((state == ST_HIGH) || (state == ST_LOW)) && !is_pop_q;
        mem_wdata = (state == ST_HIGH) ? wdata_q[WW-1:BW] : wdata_q[BW-1:0];
        pop_data  = pop_q;
    end

    // R7: the second byte of a wide transfer sits one address above the first
    a_r7_addr_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW && $past(state) == ST_HIGH) |-> (mem_addr == $past(mem_addr) + AW'(1)));

    // R9: the pointer moves only together with the completion strobe
    a_r9_sp_moves_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        (sp != $past(sp)) |-> done);

    // R11: popped value is untouched while the sequencer is leaving IDLE or FINISH
    a_r11_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_FIN) |=> $stable(pop_data));

    // R8: writes happen only in a byte cycle of a push
    a_r8_we_in_byte_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !done);
endmodule

// File: tb/stack_ptr_engine_test.sv
`timescale 1ns/1ps
module stack_ptr_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, op_pop = 1'b0, op_wide = 1'b0, stack_mode = 1'b0;
    logic [15:0] push_data = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr, pop_data, sp;
    logic [7:0]  mem_wdata;
    logic        mem_we, done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    stack_ptr_engine #(.AW(16), .BW(8), .RESET_SP(16'h0002)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .op_pop(op_pop), .op_wide(op_wide),
        .stack_mode(stack_mode), .push_data(push_data), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .pop_data(pop_data), .done(done), .sp(sp)
    );

    // byte memory, aliased on the low address byte
    logic [7:0] bmem [256];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bmem[i] <= 8'h00;
        end else if (mem_we) begin
            bmem[mem_addr[7:0]] <= mem_wdata;
        end
    end
    assign mem_rdata = bmem[mem_addr[7:0]];

    // behavioural reference model
    int mdl [256];
    int m_sp, m_nsp, m_pop;
    bit m_fin, m_is_pop, m_wide;
    int b_addr [2];
    int b_data [2];
    int b_n, b_idx;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_advance();
        if (b_idx < b_n) begin
            int a;
            a = b_addr[b_idx];
            if (m_is_pop) begin
                if (m_wide && b_idx == 0) m_pop = (mdl[a & 255] << 8) | (m_pop & 255);
                else if (m_wide)          m_pop = (m_pop & 16'hFF00) | mdl[a & 255];
                else                      m_pop = mdl[a & 255];
            end else begin
                mdl[a & 255] = b_data[b_idx];
            end
            b_idx++;
            if (b_idx == b_n) begin
                m_fin = 1'b1;
                m_sp  = m_nsp;
            end
        end else if (m_fin) begin
            m_fin = 1'b0;
            b_n = 0;
            b_idx = 0;
        end else if (req) begin
            int n, start;
            n = op_wide ? 2 : 1;
            m_is_pop = op_pop;
            m_wide = op_wide;
            if (op_pop) begin
                start = stack_mode ? m_sp : m_sp + 1;
                m_nsp = (m_sp + n) & 16'hFFFF;
            end else begin
                start = stack_mode ? m_sp - n : m_sp - (n - 1);
                m_nsp = (m_sp - n) & 16'hFFFF;
            end
            start = start & 16'hFFFF;
            b_addr[0] = start;
            b_addr[1] = (start + 1) & 16'hFFFF;
            if (op_wide) begin
                b_data[0] = (push_data >> 8) & 255;
                b_data[1] = push_data & 255;
            end else begin
                b_data[0] = push_data & 255;
            end
            b_n = n;
            b_idx = 0;
        end
    endtask

    task automatic compare();
        if (b_idx < b_n) begin
            chk("R7 addr", int'(mem_addr), b_addr[b_idx]);
            chk("R8 we", int'(mem_we), m_is_pop ? 0 : 1);
            if (!m_is_pop) chk("R7 wdata", int'(mem_wdata), b_data[b_idx]);
        end else begin
            chk("R8 we idle", int'(mem_we), 0);
        end
        chk("R8 done", int'(done), int'(m_fin));
        chk("R9 sp", int'(sp), m_sp);
        chk("R11 pop_data", int'(pop_data), m_pop);
    endtask

    task automatic step();
        model_advance();
        @(negedge clk);
        compare();
    endtask

    // one operation; poke injects a second request during the transfer
    task automatic do_op(string tag, bit p, bit w, bit m, logic [15:0] d,
                         int exp_sp, int exp_pop, bit poke);
        int cyc;
        op_pop = p; op_wide = w; stack_mode = m; push_data = d; req = 1'b1;
        step();
        cyc = 1;
        req = 1'b0;
        if (poke) begin
            req = 1'b1; op_pop = 1'b0; op_wide = 1'b0; push_data = 16'h00EE;
        end
        while (!done && cyc < 10) begin
            step();
            req = 1'b0;
            cyc++;
        end
        chk("R8 latency", cyc, w ? 3 : 2);
        chk(tag, int'(sp), exp_sp);
        if (p) chk(tag, int'(pop_data), exp_pop);
        step();
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = 0;
        m_sp = 16'h0002; m_pop = 0; m_fin = 0; b_n = 0; b_idx = 0;
        m_is_pop = 0; m_wide = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sp", int'(sp), 16'h0002);
        chk("R1 done", int'(done), 0);
        chk("R1 we", int'(mem_we), 0);
        compare();

        // next-free convention
        do_op("R3 push16 nf", 0, 1, 0, 16'hABCD, 16'h0000, 0, 0);
        do_op("R2 R9 push8 nf wrap", 0, 0, 0, 16'h115A, 16'hFFFF, 0, 0);
        do_op("R4 R11 pop8 nf", 1, 0, 0, 16'h0000, 16'h0000, 16'h005A, 0);
        do_op("R4 R7 pop16 nf", 1, 1, 0, 16'h0000, 16'h0002, 16'hABCD, 0);

        // last-used convention
        do_op("R5 push16 lu", 0, 1, 1, 16'h1234, 16'h0000, 0, 0);
        do_op("R5 R9 push8 lu wrap", 0, 0, 1, 16'h3377, 16'hFFFF, 0, 0);
        do_op("R6 pop8 lu", 1, 0, 1, 16'h0000, 16'h0000, 16'h0077, 0);
        do_op("R6 pop16 lu", 1, 1, 1, 16'h0000, 16'h0002, 16'h1234, 0);

        // R10: request during a transfer is ignored
        do_op("R10 push16 busy", 0, 1, 0, 16'hC3A5, 16'h0000, 0, 1);
        do_op("R10 pop16 after busy", 1, 1, 0, 16'h0000, 16'h0002, 16'hC3A5, 0);

        // R11: value holds while idle
        repeat (4) step();
        chk("R11 hold", int'(pop_data), 16'hC3A5);

        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end
endmodule